// File: doc/BRIEF.md
# Serial Stride Port Range Comparator

This block tests an unsigned header field, such as a 16-bit transport port, against a set of rules. Each rule holds an inclusive interval given by a lower and an upper bound. The test does not turn the interval into prefixes. It runs as a pipeline in which every stage looks at one slice of `STRIDE_W` key bits, starting with the most significant slice. Each stage compares that slice with the same slice of every rule's two bounds. For each rule and each bound the stage carries a small order state to the next stage: decided greater, decided smaller, or equal so far. The first slice that differs fixes the outcome.

After the last slice, the block reduces the two order states of each rule to one in-range bit. It ANDs the resulting vector with the match vector that entered with the key, which comes from the other match stages. The range stage can therefore sit anywhere in a chain of match stages. Software or a loader programs the bounds one at a time through a write port indexed by rule number. The bounds live in registers next to the comparators and are not kept as vectors in a memory.

Top module: `port_range_match`

## Requirements
- R1: After reset, `out_valid` and `out_vec` are 0, and every rule's interval spans the full field: the lower bound is 0 and the upper bound is all ones. A key sent before any write therefore returns its incoming vector unchanged.
- R2: A key accepted with `in_valid` high appears with `out_valid` high exactly FIELD_W/STRIDE_W + 1 clock edges later. A new key can be accepted on every cycle, and results come out in arrival order.
- R3: Bit r of `out_vec` is 1 only when bit r of `in_vec` is 1 and lower_r <= key <= upper_r, with all values compared as unsigned numbers.
- R4: Both bounds are inclusive. A key equal to the lower bound or to the upper bound of a rule is inside that rule's interval.
- R5: A rule whose lower bound is greater than its upper bound never matches any key.
- R6: A cycle with `cfg_we` high writes `cfg_data` into the bound of rule `cfg_rule`. The upper bound is written when `cfg_upper` is 1 and the lower bound when it is 0. Keys accepted from the next cycle on use the new value. No other bound changes.
- R7: Slices are compared from the most significant to the least significant. Once a slice decides "greater" or "smaller" for a bound, no later slice changes that decision. The key is equal to the bound only if every slice is equal.
- R8: While `out_valid` is low, `out_vec` is 0. The values on `in_key` and `in_vec` in cycles with `in_valid` low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Bound write strobe |
| cfg_upper | input | 1 | 1 selects the upper bound, 0 the lower bound |
| cfg_rule | input | max(1,clog2(NUM_RULES)) | Rule index of the write |
| cfg_data | input | FIELD_W | Bound value to write |
| in_valid | input | 1 | Key and vector are valid this cycle |
| in_key | input | FIELD_W | Header field under test |
| in_vec | input | NUM_RULES | Match vector from earlier stages |
| out_valid | output | 1 | Result valid |
| out_vec | output | NUM_RULES | Incoming vector ANDed with the range hits |

## Verification
The bench builds the block with a 16-bit field, 4-bit slices and 8 rules. That gives four compare stages and a five-cycle latency. Directed keys are chosen so that the deciding difference against a bound falls in the first, the middle and the last slice. They also sit exactly on each bound, one step inside and one step outside, and cross a slice boundary (an interval from 0x0FF0 to 0x100F). Randomly programmed rounds, which also produce empty intervals, stream back-to-back keys close to the programmed bounds. A plain whole-number comparison in the bench gives the expected vectors.

// File: rtl/rngcmp_pkg.sv
package rngcmp_pkg;

  // Order of the key against one bound, resolved stride by stride.
  typedef enum logic [1:0] {
    ORD_EQ = 2'b00,   // all strides so far equal
    ORD_GT = 2'b01,   // key already known greater than bound
    ORD_LT = 2'b10    // key already known smaller than bound
  } ord_t;

  // One stride step: a decided state is kept, an undecided one is
  // resolved by the current stride values (zero-extended by the caller).
  function automatic ord_t ord_step(ord_t prev, logic [31:0] key_s,
                                    logic [31:0] bnd_s);
    ord_t res;
    if (prev != ORD_EQ)      res = prev;
    else if (key_s > bnd_s)  res = ORD_GT;
    else if (key_s < bnd_s)  res = ORD_LT;
    else                     res = ORD_EQ;
    return res;
  endfunction

  // Inclusive lower bound test: fails only when the key is below.
  function automatic logic lo_pass(logic [1:0] st);
    return st != ORD_LT;
  endfunction

  // Inclusive upper bound test: fails only when the key is above.
  function automatic logic hi_pass(logic [1:0] st);
    return st != ORD_GT;
  endfunction

endpackage

// File: rtl/rngcmp_bank.sv
module rngcmp_bank #(
  parameter int N     = 8,
  parameter int W     = 16,
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_upper,
  input  logic [IDX_W-1:0]        wr_rule,
  input  logic [W-1:0]            wr_val,
  output logic [N-1:0][W-1:0]     lo_q,
  output logic [N-1:0][W-1:0]     hi_q
);

  for (genvar r = 0; r < N; r++) begin : g_rule
    logic sel;
    assign sel = wr_en && (wr_rule == IDX_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[r] <= '0;
        hi_q[r] <= '1;
      end else if (sel) begin
        if (wr_upper) hi_q[r] <= wr_val;
        else          lo_q[r] <= wr_val;
      end
    end
  end

endmodule

// File: rtl/rngcmp_stage.sv
module rngcmp_stage
  import rngcmp_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16,
  parameter int K = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [W-1:0]         in_key,
  input  logic [N-1:0]         in_vec,
  input  logic [N-1:0][1:0]    in_lo_st,
  input  logic [N-1:0][1:0]    in_hi_st,
  input  logic [N-1:0][K-1:0]  lo_s,
  input  logic [N-1:0][K-1:0]  hi_s,
  output logic                 out_vld,
  output logic [W-1:0]         out_key,
  output logic [N-1:0]         out_vec,
  output logic [N-1:0][1:0]    out_lo_st,
  output logic [N-1:0][1:0]    out_hi_st
);

  // The key arrives left-aligned: its top K bits are this stage's stride.
  logic [K-1:0]        key_s;
  logic [N-1:0][1:0]   nxt_lo;
  logic [N-1:0][1:0]   nxt_hi;

  assign key_s = in_key[W-1 -: K];

  always_comb begin
    for (int r = 0; r < N; r++) begin
      nxt_lo[r] = ord_step(ord_t'(in_lo_st[r]), 32'(key_s), 32'(lo_s[r]));
      nxt_hi[r] = ord_step(ord_t'(in_hi_st[r]), 32'(key_s), 32'(hi_s[r]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_key   <= '0;
      out_vec   <= '0;
      out_lo_st <= '0;
      out_hi_st <= '0;
    end else begin
      out_vld   <= in_vld;
      out_key   <= in_key << K;
      out_vec   <= in_vld ? in_vec : '0;
      out_lo_st <= nxt_lo;
      out_hi_st <= nxt_hi;
    end
  end

endmodule

// File: rtl/port_range_match.sv
module port_range_match
  import rngcmp_pkg::*;
#(
  parameter int FIELD_W   = 16,
  parameter int STRIDE_W  = 4,
  parameter int NUM_RULES = 8
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            cfg_we,
  input  logic                                            cfg_upper,
  input  logic [((NUM_RULES > 1) ? $clog2(NUM_RULES) : 1)-1:0] cfg_rule,
  input  logic [FIELD_W-1:0]                              cfg_data,
  input  logic                                            in_valid,
  input  logic [FIELD_W-1:0]                              in_key,
  input  logic [NUM_RULES-1:0]                            in_vec,
  output logic                                            out_valid,
  output logic [NUM_RULES-1:0]                            out_vec
);

  localparam int NSTG  = FIELD_W / STRIDE_W;
  localparam int RIDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1;

  // Bound registers
  logic [NUM_RULES-1:0][FIELD_W-1:0] lo_q;
  logic [NUM_RULES-1:0][FIELD_W-1:0] hi_q;

  rngcmp_bank #(.N(NUM_RULES), .W(FIELD_W), .IDX_W(RIDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_upper (cfg_upper),
    .wr_rule  (cfg_rule),
    .wr_val   (cfg_data),
    .lo_q     (lo_q),
    .hi_q     (hi_q)
  );

  // Pipeline chain: index 0 is the block input, index s+1 the output of stage s.
  wire [NSTG:0]                         ch_vld;
  wire [NSTG:0][FIELD_W-1:0]            ch_key;
  wire [NSTG:0][NUM_RULES-1:0]          ch_vec;
  wire [NSTG:0][NUM_RULES-1:0][1:0]     ch_lo;
  wire [NSTG:0][NUM_RULES-1:0][1:0]     ch_hi;

  assign ch_vld[0] = in_valid;
  assign ch_key[0] = in_key;
  assign ch_vec[0] = in_vec;
  assign ch_lo[0]  = '0;   // every bound starts undecided
  assign ch_hi[0]  = '0;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    localparam int MSB = FIELD_W - 1 - s * STRIDE_W;
    logic [NUM_RULES-1:0][STRIDE_W-1:0] lo_s;
    logic [NUM_RULES-1:0][STRIDE_W-1:0] hi_s;

    for (genvar r = 0; r < NUM_RULES; r++) begin : g_slc
      assign lo_s[r] = lo_q[r][MSB -: STRIDE_W];
      assign hi_s[r] = hi_q[r][MSB -: STRIDE_W];
    end

    rngcmp_stage #(.N(NUM_RULES), .W(FIELD_W), .K(STRIDE_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (ch_vld[s]),
      .in_key    (ch_key[s]),
      .in_vec    (ch_vec[s]),
      .in_lo_st  (ch_lo[s]),
      .in_hi_st  (ch_hi[s]),
      .lo_s      (lo_s),
      .hi_s      (hi_s),
      .out_vld   (ch_vld[s+1]),
      .out_key   (ch_key[s+1]),
      .out_vec   (ch_vec[s+1]),
      .out_lo_st (ch_lo[s+1]),
      .out_hi_st (ch_hi[s+1])
    );
  end

  // Range hit per rule after the last stride, named for the checker.
  logic [NUM_RULES-1:0] rng_hit;

  always_comb begin
    for (int r = 0; r < NUM_RULES; r++)
      rng_hit[r] = lo_pass(ch_lo[NSTG][r]) & hi_pass(ch_hi[NSTG][r]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= ch_vld[NSTG];
      out_vec   <= ch_vld[NSTG] ? (ch_vec[NSTG] & rng_hit) : '0;
    end
  end

endmodule

// File: rtl/rngcmp_chk.sv
module rngcmp_chk #(
  parameter int N     = 8,
  parameter int W     = 16,
  parameter int NSTG  = 4,
  parameter int IDX_W = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_we,
  input logic                        cfg_upper,
  input logic [IDX_W-1:0]            cfg_rule,
  input logic [W-1:0]                cfg_data,
  input logic [N-1:0][W-1:0]         lo_q,
  input logic [N-1:0][W-1:0]         hi_q,
  input logic [NSTG:0]               ch_vld,
  input logic [NSTG:0][N-1:0]        ch_vec,
  input logic [NSTG:0][N-1:0][1:0]   ch_lo,
  input logic [NSTG:0][N-1:0][1:0]   ch_hi,
  input logic                        out_valid,
  input logic [N-1:0]                out_vec
);

  // R2: valid advances exactly one stage per clock
  p_stage_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ch_vld[NSTG:1] == $past(ch_vld[NSTG-1:0]));

  p_out_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(ch_vld[NSTG]));

  // R8: idle output carries no bits
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_vec == '0);

  // R3: the result never sets a bit the incoming vector lacked
  p_out_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vec & ~$past(ch_vec[NSTG])) == '0);

  // R7: a decided order is never revised by a later stride
  for (genvar s = 1; s <= NSTG; s++) begin : g_s
    for (genvar r = 0; r < N; r++) begin : g_r
      p_lo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ch_vld[s-1]) && $past(ch_lo[s-1][r]) != 2'b00)
          |-> ch_lo[s][r] == $past(ch_lo[s-1][r]));
      p_hi_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ch_vld[s-1]) && $past(ch_hi[s-1][r]) != 2'b00)
          |-> ch_hi[s][r] == $past(ch_hi[s-1][r]));
    end
  end

  // R6: writes land in the addressed bound only
  for (genvar r = 0; r < N; r++) begin : g_w
    p_lo_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_upper && cfg_rule == IDX_W'(r)) |=> lo_q[r] == $past(cfg_data));
    p_hi_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_upper && cfg_rule == IDX_W'(r)) |=> hi_q[r] == $past(cfg_data));
    p_lo_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && !cfg_upper && cfg_rule == IDX_W'(r)) |=> $stable(lo_q[r]));
    p_hi_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_upper && cfg_rule == IDX_W'(r)) |=> $stable(hi_q[r]));
  end

endmodule

bind port_range_match rngcmp_chk #(
  .N(NUM_RULES), .W(FIELD_W), .NSTG(NSTG), .IDX_W(RIDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_upper (cfg_upper),
  .cfg_rule  (cfg_rule),
  .cfg_data  (cfg_data),
  .lo_q      (lo_q),
  .hi_q      (hi_q),
  .ch_vld    (ch_vld),
  .ch_vec    (ch_vec),
  .ch_lo     (ch_lo),
  .ch_hi     (ch_hi),
  .out_valid (out_valid),
  .out_vec   (out_vec)
);

// File: tb/sim_port_range_match.sv
module sim_port_range_match;
  localparam int FW  = 16;
  localparam int SW  = 4;
  localparam int NR  = 8;
  localparam int RW  = 3;
  localparam int LAT = FW / SW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cfg_we = 1'b0, cfg_upper = 1'b0;
  logic [RW-1:0] cfg_rule = '0;
  logic [FW-1:0] cfg_data = '0;
  logic          in_valid = 1'b0;
  logic [FW-1:0] in_key = '0;
  logic [NR-1:0] in_vec = '0;
  logic          out_valid;
  logic [NR-1:0] out_vec;

  port_range_match #(.FIELD_W(FW), .STRIDE_W(SW), .NUM_RULES(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_upper(cfg_upper),
    .cfg_rule(cfg_rule), .cfg_data(cfg_data), .in_valid(in_valid),
    .in_key(in_key), .in_vec(in_vec), .out_valid(out_valid), .out_vec(out_vec));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [FW-1:0] sh_lo [NR];
  logic [FW-1:0] sh_hi [NR];
  logic          h_vld [64];
  logic [NR-1:0] h_exp [64];
  string         h_tag [64];

  // Whole-number interval test against the shadow bounds.
  function automatic logic [NR-1:0] ref_match(logic [FW-1:0] k, logic [NR-1:0] v);
    logic [NR-1:0] m;
    for (int r = 0; r < NR; r++)
      m[r] = v[r] && (k >= sh_lo[r]) && (k <= sh_hi[r]);
    return m;
  endfunction

  task automatic check(string tag, logic gv, logic [NR-1:0] g, logic ev, logic [NR-1:0] e);
    n_chk++;
    if (gv !== ev || g !== e) begin
      n_fail++;
      $display("FAIL %s: valid/vec actual %0b/%h expected %0b/%h", tag, gv, g, ev, e);
    end
  endtask

  // One cycle: compare the output due now, then drive the next input.
  task automatic step(logic v, logic [FW-1:0] k, logic [NR-1:0] vec, string tag);
    int slot;
    @(negedge clk);
    cfg_we = 1'b0;
    if (cyc >= LAT) begin
      slot = (cyc - LAT) % 64;
      check(h_tag[slot], out_valid, out_vec, h_vld[slot], h_exp[slot]);
    end
    in_valid = v; in_key = k; in_vec = vec;
    slot = cyc % 64;
    h_vld[slot] = v;
    h_exp[slot] = v ? ref_match(k, vec) : '0;
    h_tag[slot] = tag;
    cyc++;
  endtask

  // R8: idle cycles carry noise on key and vector
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, FW'($urandom), NR'($urandom), "R8");
  endtask

  task automatic wr(int r, logic up, logic [FW-1:0] val);
    step(1'b0, FW'($urandom), NR'($urandom), "R8");
    cfg_we = 1'b1; cfg_upper = up; cfg_rule = RW'(r); cfg_data = val;
    if (up) sh_hi[r] = val; else sh_lo[r] = val;
  endtask

  task automatic key(logic [FW-1:0] k, string tag);
    step(1'b1, k, '1, tag);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL R2: watchdog expired, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 64; i++) begin h_vld[i] = 1'b0; h_exp[i] = '0; h_tag[i] = "R8"; end
    for (int r = 0; r < NR; r++) begin sh_lo[r] = '0; sh_hi[r] = '1; end
    repeat (4) @(negedge clk);
    check("R1", out_valid, out_vec, 1'b0, '0);
    rst_n = 1'b1;

    // R1: full-span default intervals pass the vector through
    step(1'b1, 16'h0000, 8'hC3, "R1");
    step(1'b1, 16'hFFFF, 8'h3C, "R1");
    step(1'b1, 16'h8421, 8'hFF, "R1");
    idle(LAT);

    wr(0, 0, 16'h0000); wr(0, 1, 16'h03FF);
    wr(1, 0, 16'h0400); wr(1, 1, 16'hFFFF);
    wr(2, 0, 16'h1234); wr(2, 1, 16'h1234);
    wr(3, 0, 16'h5000); wr(3, 1, 16'h4FFF);
    wr(4, 0, 16'h0FF0); wr(4, 1, 16'h100F);
    wr(5, 0, 16'h8000); wr(5, 1, 16'hFFFF);
    wr(6, 0, 16'h00A0); wr(6, 1, 16'h00AF);
    wr(7, 0, 16'h7FFF); wr(7, 1, 16'h8001);
    idle(1);

    // R4: keys on and next to the bounds
    key(16'h03FF, "R4"); key(16'h0400, "R4"); key(16'h1234, "R4");
    key(16'h1233, "R4"); key(16'h0FF0, "R4"); key(16'h100F, "R4");
    key(16'h7FFF, "R4"); key(16'h8001, "R4");
    // R5: the empty interval of rule 3
    key(16'h4FFF, "R5"); key(16'h5000, "R5");
    // R7: deciding difference in first, middle and last stride
    key(16'h1235, "R7"); key(16'h0FEF, "R7"); key(16'h1010, "R7");
    key(16'h00A5, "R7"); key(16'h00B0, "R7"); key(16'h8002, "R7");
    key(16'h9000, "R7");
    // R3: incoming vector masks the range hits
    step(1'b1, 16'h00A7, 8'h5A, "R3");
    step(1'b1, 16'h1234, 8'hA5, "R3");
    key(16'h0000, "R3"); key(16'hFFFF, "R3");
    idle(LAT);

    // R6: rewrite one bound, keys right after use it
    wr(2, 1, 16'h1240);
    key(16'h123F, "R6"); key(16'h1240, "R6"); key(16'h1241, "R6");
    key(16'h0200, "R6");
    idle(LAT);

    // R2/R3: random rounds, back-to-back keys near programmed bounds
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int r = 0; r < NR; r++) begin
        wr(r, 0, FW'($urandom));
        wr(r, 1, FW'($urandom));
      end
      for (int i = 0; i < 300; i++) begin
        int sel;
        logic [FW-1:0] k;
        sel = int'($urandom % NR);
        if ($urandom % 2) k = FW'($urandom);
        else k = (($urandom % 2) ? sh_lo[sel] : sh_hi[sel]) + FW'($urandom % 5) - FW'(2);
        step(($urandom % 8) != 0, k, NR'($urandom), (i % 2) ? "R2" : "R3");
      end
      idle(LAT);
    end
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule